// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Level Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. A shared active-low reset clears both sides. While reset is held, the block samples a timing-select input and two offset inputs. The sampled select fixes how the read side behaves until the next reset.

In standard timing, each word must be pulled out with the active-low read strobe. An empty indicator tells the reader whether anything is stored, and a full indicator tells the writer when to stop. In fall-through timing, the oldest word moves into the output register on its own. The read strobe then discards that word and brings forward the next one. The reader sees a data-valid indicator, and the writer sees a "no room" indicator. The output register counts as one more storage slot, so in fall-through timing every level threshold sits one word higher.

On top of these, the block drives three level flags: half full, almost full (using the full offset) and almost empty (using the empty offset). The write and read pointers cross between the clock domains in Gray code through two-flop synchronizers. As a result, every flag can lag the true fill level but never leads it.

Top module: `dcfifo_flags`

## Requirements
- R1: The timing select (`fwft_sel`) is sampled while `rst_n` is low: 0 gives standard timing and 1 gives fall-through timing. After reset, standard timing shows `out_flag`=0 (empty) and `in_flag`=1 (room). Fall-through timing shows `out_flag`=1 (no valid data) and `in_flag`=0 (room).
- R2: In standard timing, a word is delivered on `dout` only after a read-clock edge with `rd_n`=0, and words come out in write order. `out_flag` is 1 exactly when at least one word is stored.
- R3: In fall-through timing, the first word written into an empty FIFO reaches `dout` with `out_flag`=0 on the third rising read-clock edge after the write edge, not earlier, and without any read strobe. Later words follow in write order, one per `rd_n`=0 edge.
- R4: With T words held in total and E the sampled empty offset, `aempty_n` is 1 exactly when T ≥ E+1 in standard timing, or when T ≥ E+2 in fall-through timing.
- R5: `hf_n` is 0 exactly when T ≥ DEPTH/2+1 in standard timing, or when T ≥ DEPTH/2+2 in fall-through timing.
- R6: With F the sampled full offset, `af_n` is 0 exactly when T ≥ DEPTH−F in standard timing, or when T ≥ DEPTH+1−F in fall-through timing.
- R7: In standard timing, `in_flag` drops to 0 once DEPTH words are held. In fall-through timing, it rises to 1 once DEPTH+1 words are held. While the flag shows full, writes are refused, and the first read afterwards restores the flag.
- R8: A read strobe while the FIFO is empty has no effect: `dout` keeps its value and the next word written is the next word read.
- R9: The occupancy seen in either clock domain stays between 0 and DEPTH. Each pointer's Gray value changes by at most one bit per edge. A write refused while full never shows up in the data read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains; the configuration is sampled while low |
| fwft_sel | input | 1 | Timing select, sampled in reset: 0 standard, 1 fall-through |
| empty_off | input | AW | Empty offset E, sampled in reset |
| full_off | input | AW | Full offset F, sampled in reset |
| wr_n | input | 1 | Active-low write strobe |
| din | input | WIDTH | Write data |
| in_flag | output | 1 | Standard: 1 room, 0 full; fall-through: 0 room, 1 full |
| hf_n | output | 1 | Low when more than half full |
| af_n | output | 1 | Low when almost full |
| rd_n | input | 1 | Active-low read strobe |
| dout | output | WIDTH | Read data register |
| out_flag | output | 1 | Standard: 1 data stored, 0 empty; fall-through: 0 valid word on dout, 1 none |
| aempty_n | output | 1 | Low while almost empty |

## Verification
The bench runs both timing modes against small, middle and extreme offsets. At each of these configurations it fills the FIFO one word at a time, past full, and then drains it. Every flag is compared against thresholds computed from the total count, so a design that forgot the extra output-register slot in fall-through timing fails by exactly one word at each threshold. Checks on the fall-through latency catch a word that appears after two read edges, which would mean a bypassed synchronizer. Reads on an empty FIFO, followed by a fresh write, catch a read pointer that slips and later returns stale or skipped data. The extra write attempted while full catches a design that overwrites the oldest word.

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             fwft_sel,
  input  logic [AW-1:0]    empty_off,
  input  logic [AW-1:0]    full_off,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  output logic             in_flag,
  output logic             hf_n,
  output logic             af_n,
  input  logic             rd_n,
  output logic [WIDTH-1:0] dout,
  output logic             out_flag,
  output logic             aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] D_P  = PW'(DEPTH);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wg_q, rg_s1, rg_s2, rg_q;
  logic [PW-1:0] wptr_nx, rbin_w, wcnt_nx;
  logic          full_q, mode_w, wr_ok;
  logic [AW-1:0] foff_q;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      mode_w <= fwft_sel;
      foff_q <= full_off;
    end
  end

  assign wr_ok   = !wr_n && !full_q;
  assign wptr_nx = wptr + PW'(wr_ok);
  assign rbin_w  = g2b(rg_s2);
  assign wcnt_nx = wptr_nx - rbin_w;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wg_q   <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
      full_q <= 1'b0;
      hf_n   <= 1'b1;
      af_n   <= 1'b1;
    end else begin
      wptr   <= wptr_nx;
      wg_q   <= b2g(wptr_nx);
      rg_s1  <= rg_q;
      rg_s2  <= rg_s1;
      full_q <= (wcnt_nx == D_P);
      hf_n   <= !(wcnt_nx > HALF);
      af_n   <= !(wcnt_nx >= (D_P - {1'b0, foff_q}));
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= din;
  end

  assign in_flag = mode_w ? full_q : !full_q;

  // R9
  wr_occ_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wptr - rbin_w) <= D_P);
  // R9
  wr_gray_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wg_q ^ $past(wg_q)) <= 1);
  // R7
  wr_block_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_n && full_q) |=> $stable(wptr));

  // read domain
  logic [PW-1:0] rptr, wg_s1, wg_s2;
  logic [PW-1:0] rptr_nx, wbin_r, rcnt_nx;
  logic          mode_r, ov, ef_q, std_rd, fw_load, pop, mem_has;
  logic [AW-1:0] eoff_q;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      mode_r <= fwft_sel;
      eoff_q <= empty_off;
    end
  end

  assign wbin_r  = g2b(wg_s2);
  assign mem_has = (wbin_r != rptr);
  assign std_rd  = !mode_r && !rd_n && ef_q;
  assign fw_load = mode_r && mem_has && (!ov || !rd_n);
  assign pop     = std_rd || fw_load;
  assign rptr_nx = rptr + PW'(pop);
  assign rcnt_nx = wbin_r - rptr_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rg_q     <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      ef_q     <= 1'b0;
      ov       <= 1'b0;
      aempty_n <= 1'b0;
      dout     <= '0;
    end else begin
      rptr     <= rptr_nx;
      rg_q     <= b2g(rptr_nx);
      wg_s1    <= wg_q;
      wg_s2    <= wg_s1;
      ef_q     <= (rcnt_nx != '0);
      aempty_n <= (rcnt_nx > {1'b0, eoff_q});
      if (pop) dout <= mem[rptr[AW-1:0]];
      if (fw_load) ov <= 1'b1;
      else if (!rd_n) ov <= 1'b0;
    end
  end

  assign out_flag = mode_r ? !ov : ef_q;

  // R9
  rd_occ_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (wbin_r - rptr) <= D_P);
  // R9
  rd_gray_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rg_q ^ $past(rg_q)) <= 1);
  // R2
  std_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_r && rd_n) |=> $stable(rptr) && $stable(dout));
  // R8
  empty_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_r && !ef_q) |=> $stable(rptr));
  // R3
  fw_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(ov) |-> $past(!rd_n));
endmodule

// File: tb/tb_dcfifo_flags.sv
module tb_dcfifo_flags;
  localparam int W = 8;
  localparam int AW = 4;
  localparam int D = 16;

  logic wclk, rclk, rst_n, fwft_sel, wr_n, rd_n;
  logic [AW-1:0] empty_off, full_off;
  logic [W-1:0] din, dout;
  logic in_flag, hf_n, af_n, out_flag, aempty_n;

  int checks = 0;
  int fails = 0;
  int md, nn, mm;

  dcfifo_flags #(.WIDTH(W), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .empty_off(empty_off), .full_off(full_off), .wr_n(wr_n), .din(din),
    .in_flag(in_flag), .hf_n(hf_n), .af_n(af_n), .rd_n(rd_n), .dout(dout),
    .out_flag(out_flag), .aempty_n(aempty_n));

  initial wclk = 0;
  always #10 wclk = ~wclk;
  initial begin
    rclk = 0;
    #3;
    forever #14 rclk = ~rclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d E %0d F %0d)", req, act, exp, md, nn, mm);
    end
  endtask

  task automatic settle;
    repeat (8) @(negedge rclk);
  endtask

  task automatic flags(input string tag, input int t);
    int mem;
    mem = (md == 1 && t > 0) ? t - 1 : t;
    if (md == 0) chk({tag, " R2 out_flag"}, out_flag, (t > 0) ? 1 : 0);
    else         chk({tag, " R3 out_flag"}, out_flag, (t > 0) ? 0 : 1);
    chk({tag, " R4 aempty_n"}, aempty_n, (t >= nn + 1 + md) ? 1 : 0);
    chk({tag, " R5 hf_n"}, hf_n, (t >= D / 2 + 1 + md) ? 0 : 1);
    chk({tag, " R6 af_n"}, af_n, (t >= D - mm + md) ? 0 : 1);
    if (md == 0) chk({tag, " R7 in_flag"}, in_flag, (mem == D) ? 0 : 1);
    else         chk({tag, " R7 in_flag"}, in_flag, (mem == D) ? 1 : 0);
  endtask

  task automatic wr(input logic [W-1:0] v);
    @(negedge wclk);
    wr_n = 0;
    din = v;
    @(negedge wclk);
    wr_n = 1;
  endtask

  task automatic rd;
    @(negedge rclk);
    rd_n = 0;
    @(negedge rclk);
    rd_n = 1;
  endtask

  task automatic run_cfg(input int m, input int n, input int f, input int base);
    int cap;
    logic [W-1:0] held;
    md = m; nn = n; mm = f;
    cap = D + m;
    rst_n = 0; fwft_sel = m[0]; empty_off = AW'(n); full_off = AW'(f);
    wr_n = 1; rd_n = 1; din = '0;
    repeat (4) @(negedge wclk);
    rst_n = 1;
    settle;
    // R1 reset state
    chk("R1 out_flag after reset", out_flag, m == 1 ? 1 : 0);
    chk("R1 in_flag after reset", in_flag, m == 1 ? 0 : 1);
    flags("R1", 0);
    for (int t = 1; t <= cap + 1; t++) begin
      if (m == 1 && t == 1) begin
        @(negedge wclk);
        wr_n = 0;
        din = W'(base);
        @(posedge wclk);
        fork
          begin @(negedge wclk); wr_n = 1; end
          begin
            repeat (2) @(posedge rclk);
            #1 chk("R3 not valid after two read edges", out_flag, 1);
            @(posedge rclk);
            #1 chk("R3 valid after third read edge", out_flag, 0);
            chk("R3 first word on dout", dout, base & 8'hFF);
          end
        join
      end else begin
        wr(W'(base + t - 1));
      end
      settle;
      if (t > cap) flags("R9 refused write", cap);
      else flags("fill", t);
    end
    for (int r = 0; r < cap; r++) begin
      if (m == 1) begin
        chk("R3 head word", dout, (base + r) & 8'hFF);
        rd;
        settle;
      end else begin
        rd;
        settle;
        chk("R2 read word", dout, (base + r) & 8'hFF);
      end
      flags("drain", cap - r - 1);
    end
    held = dout;
    rd;
    settle;
    chk("R8 dout held on empty read", dout, held);
    flags("R8 empty read", 0);
    wr(W'(base + 100));
    settle;
    if (m == 0) begin
      rd;
      settle;
    end
    chk("R8 next word after empty read", dout, (base + 100) & 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; wr_n = 1; rd_n = 1; din = '0;
    fwft_sel = 0; empty_off = '0; full_off = '0;
    for (int m = 0; m < 2; m++) begin
      run_cfg(m, 0, 1, 16 + m * 64);
      run_cfg(m, 3, 4, 40 + m * 64);
      run_cfg(m, 7, 15, 70 + m * 64);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule